// File: doc/BRIEF.md
# Dual-Branch Glitch-Free CPU Clock Selector

This block builds a processor clock out of a small tree of clock multiplexers. Two identical branches each choose one of three free-running references: the crystal oscillator, the fixed clock divided by two, or the fixed clock divided by three. Each branch can also send its chosen reference through an integer divider before its output. A dynamic stage then picks one of the two branches, and a last stage picks either that result or the system PLL clock. The PLL itself is outside this block.

Branch 1 acts as a parking clock at a safe frequency. Software moves the processor onto branch 1, reprograms branch 0, then moves back. While branch 1 is in use, the block ignores writes to its settings.

A divider value written through the control word is only staged at first. It reaches the running divider when the commit bit falls from 1 to 0, and the divider switches to the new ratio at its next terminal count. Every multiplexer switch uses a synchronized handshake: the old clock is turned off on its own falling edge before the new clock is turned on on its own falling edge. A done output tells software when all requested switches and commits have settled.

Top module: `cpu_clk_tree`

## Requirements
- R1: After reset, branch 0 is selected and uses the crystal source with no division, the last stage takes the dynamic path, `cpu_clk` runs at the crystal period, and `cfg_done` is 1.
- R2: Control word bits [1:0] (branch 0) and [10:9] (branch 1) select the branch source: code 1 is the fixed/2 clock, code 2 is the fixed/3 clock, and codes 0 and 3 are the crystal clock.
- R3: Bit 2 (branch 0) and bit 11 (branch 1) route the source through the divider. The committed 6-bit value N gives a period ratio of N+1 for N from 1 to 63, and a ratio of 2 for N = 0.
- R4: Bit 18 selects branch 1 (0 selects branch 0). Bit 19 switches the output to the PLL clock (0 selects the dynamic path).
- R5: The divider fields are bits [8:3] (branch 0) and [17:12] (branch 1). A written value does not change the output. It is committed only by a write that clears bit 20 while bit 20 is stored as 1, and the committed value is the one carried in that clearing write.
- R6: A committed ratio is applied at the next terminal count of the running divider. The divider count always stays below its current ratio.
- R7: Switching is glitch-free. At most one input of any multiplexer is enabled at a time, and `cpu_clk` never shows a high or low phase shorter than the shortest half period among its sources.
- R8: While bit 18 is stored as 1, or branch 1 is still the active branch, writes leave the branch 1 source, divide-enable and staged divider fields unchanged, and a commit does not change the committed branch 1 ratio.
- R9: `cfg_done` goes to 0 in the cycle after a write that changes the branch selection or commits a divider while it was 1. It returns to 1 only once every multiplexer and divider has reached the requested setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| cfg_clk | input | 1 | Control interface clock |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 21 | Control word (field positions in R2 to R5) |
| osc_clk | input | 1 | Crystal reference clock |
| fdiv2_clk | input | 1 | Fixed clock divided by two |
| fdiv3_clk | input | 1 | Fixed clock divided by three |
| pll_clk | input | 1 | System PLL clock |
| cpu_clk | output | 1 | Selected processor clock |
| cfg_done | output | 1 | All requested switches and commits have completed |

## Verification
The assertions check on every cycle that no multiplexer ever has two legs enabled, that each divider count stays in range and its ratio changes only at terminal count, that locked branch 1 fields and the committed values move only as allowed, and that `cfg_done` drops after a switch or a commit. Only the bench scenarios can show the actual output period for each source, divide and branch combination. They also show that staged but uncommitted values leave the output unchanged, that the parking branch keeps its frequency under attempted writes, and that `cpu_clk` keeps a minimum pulse width across all the switches.

// File: rtl/cpu_clk_pkg.sv
`timescale 1ns/1ps
package cpu_clk_pkg;
  localparam int DIV_W   = 6;
  localparam int RATIO_W = DIV_W + 1;
  localparam int SRC_N   = 3;
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(1);

  // control word, LSB first: b0_src, b0_div, b0_n, b1_src, b1_div, b1_n, br_sel, use_pll, commit
  typedef struct packed {
    logic             commit;
    logic             use_pll;
    logic             br_sel;
    logic [DIV_W-1:0] b1_n;
    logic             b1_div;
    logic [1:0]       b1_src;
    logic [DIV_W-1:0] b0_n;
    logic             b0_div;
    logic [1:0]       b0_src;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam ctl_t CTL_RST = '{commit: 1'b0, use_pll: 1'b0, br_sel: 1'b0,
                               b1_n: RST_DIV, b1_div: 1'b0, b1_src: 2'd0,
                               b0_n: RST_DIV, b0_div: 1'b0, b0_src: 2'd0};

  // period ratio for a committed divider value
  function automatic logic [RATIO_W-1:0] div_ratio(input logic [DIV_W-1:0] n);
    if (n == '0) return RATIO_W'(2);
    return RATIO_W'(n) + RATIO_W'(1);
  endfunction

  // source code to one-hot leg of the pre-mux
  function automatic logic [SRC_N-1:0] src_onehot(input logic [1:0] code);
    case (code)
      2'd1:    return SRC_N'(2);
      2'd2:    return SRC_N'(4);
      default: return SRC_N'(1);
    endcase
  endfunction

  function automatic logic [1:0] pair_onehot(input logic b);
    return b ? 2'b10 : 2'b01;
  endfunction
endpackage

// File: rtl/glitchless_mux.sv
`timescale 1ns/1ps
module glitchless_mux #(
  parameter int N       = 2,
  parameter int RST_IDX = 0
) (
  input  logic         rst_n,
  input  logic [N-1:0] clk_in,
  input  logic [N-1:0] sel_oh,
  output logic         clk_out,
  output logic [N-1:0] act_o
);
  logic [N-1:0] en_vec;
  logic [N-1:0] gated;

  for (genvar i = 0; i < N; i++) begin : g_leg
    localparam logic RV = (i == RST_IDX);
    logic req, s1, s2, en_r;
    // a leg may only start once every other leg has stopped
    assign req = sel_oh[i] & ~|(en_vec & ~(N'(1) << i));
    always_ff @(posedge clk_in[i] or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RV;
        s2 <= RV;
      end else begin
        s1 <= req;
        s2 <= s1;
      end
    end
    // enable changes only while this leg's clock is low
    always_ff @(negedge clk_in[i] or negedge rst_n) begin
      if (!rst_n) en_r <= RV;
      else        en_r <= s2;
    end
    assign en_vec[i] = en_r;
    assign gated[i]  = clk_in[i] & en_r;
  end

  assign clk_out = |gated;
  assign act_o   = en_vec;

  always_comb begin
    AST_MUX_EXCLUSIVE: assert ($onehot0(en_vec)) else $error("mux has two legs enabled"); // R7
  end
endmodule

// File: rtl/ratio_divider.sv
`timescale 1ns/1ps
module ratio_divider
  import cpu_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_t,
  input  logic [DIV_W-1:0] cmt_n,
  output logic             ack_t,
  output logic             div_o
);
  logic               req_s1, req_s2;
  logic [RATIO_W-1:0] ratio_q, ratio_nx, cnt_q, cnt_nx;
  logic               at_tc, apply;

  assign at_tc    = (cnt_q == ratio_q - RATIO_W'(1));
  assign apply    = at_tc & (req_s2 != ack_t);
  assign ratio_nx = apply ? div_ratio(cmt_n) : ratio_q;
  assign cnt_nx   = at_tc ? '0 : cnt_q + RATIO_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_s1  <= 1'b0;
      req_s2  <= 1'b0;
      ack_t   <= 1'b0;
      ratio_q <= div_ratio(RST_DIV);
      cnt_q   <= '0;
      div_o   <= 1'b0;
    end else begin
      req_s1  <= req_t;
      req_s2  <= req_s1;
      if (apply) ack_t <= req_s2;
      ratio_q <= ratio_nx;
      cnt_q   <= cnt_nx;
      div_o   <= (cnt_nx < (ratio_nx >> 1));
    end
  end

  AST_DIV_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt_q < ratio_q) else $error("divider count out of range"); // R6
  AST_DIV_RATIO_AT_TC: assert property (@(posedge clk) disable iff (!rst_n) !at_tc |=> $stable(ratio_q)) else $error("ratio changed mid-period"); // R6
endmodule

// File: rtl/clk_branch.sv
`timescale 1ns/1ps
module clk_branch
  import cpu_clk_pkg::*;
(
  input  logic             rst_n,
  input  logic [SRC_N-1:0] ref_clk,
  input  logic [1:0]       src,
  input  logic             use_div,
  input  logic             req_t,
  input  logic [DIV_W-1:0] cmt_n,
  output logic             ack_t,
  output logic [SRC_N-1:0] pre_act,
  output logic [1:0]       post_act,
  output logic             clk_o
);
  logic pre_clk, div_clk;

  glitchless_mux #(.N(SRC_N), .RST_IDX(0)) u_pre (
    .rst_n   (rst_n),
    .clk_in  (ref_clk),
    .sel_oh  (src_onehot(src)),
    .clk_out (pre_clk),
    .act_o   (pre_act)
  );

  ratio_divider u_div (
    .clk   (pre_clk),
    .rst_n (rst_n),
    .req_t (req_t),
    .cmt_n (cmt_n),
    .ack_t (ack_t),
    .div_o (div_clk)
  );

  glitchless_mux #(.N(2), .RST_IDX(0)) u_post (
    .rst_n   (rst_n),
    .clk_in  ({div_clk, pre_clk}),
    .sel_oh  (pair_onehot(use_div)),
    .clk_out (clk_o),
    .act_o   (post_act)
  );
endmodule

// File: rtl/cpu_clk_tree.sv
`timescale 1ns/1ps
module cpu_clk_tree
  import cpu_clk_pkg::*;
(
  input  logic             rst_n,
  input  logic             cfg_clk,
  input  logic             cfg_we,
  input  logic [CTL_W-1:0] cfg_wdata,
  input  logic             osc_clk,
  input  logic             fdiv2_clk,
  input  logic             fdiv3_clk,
  input  logic             pll_clk,
  output logic             cpu_clk,
  output logic             cfg_done
);
  localparam int BR_FB  = SRC_N + 2;
  localparam int FB_W   = 2 * BR_FB + 4;
  localparam int DYN_B1 = 2 * BR_FB + 1;
  localparam logic [FB_W-1:0] FB_RST = {pair_onehot(1'b0), pair_onehot(1'b0),
                                        pair_onehot(1'b0), src_onehot(2'd0),
                                        pair_onehot(1'b0), src_onehot(2'd0)};

  ctl_t             ctl_q, wr_ctl, nxt_ctl;
  logic [DIV_W-1:0] cmt0_q, cmt1_q;
  logic             req0_q, req1_q;
  logic             park_lock, commit_fall;
  logic [FB_W-1:0]  fb_raw, fb_s1, fb_s2, fb_want;
  logic [1:0]       ack_raw, ack_s1, ack_s2;

  logic [SRC_N-1:0] b0_pre, b1_pre;
  logic [1:0]       b0_post, b1_post, dyn_act, fin_act;
  logic             br0_clk, br1_clk, dyn_clk;
  logic [SRC_N-1:0] refs;

  assign refs   = {fdiv3_clk, fdiv2_clk, osc_clk};
  assign wr_ctl = ctl_t'(cfg_wdata);

  // parking branch is frozen while requested or still running
  assign park_lock   = ctl_q.br_sel | fb_s2[DYN_B1];
  assign commit_fall = cfg_we & ctl_q.commit & ~wr_ctl.commit;

  always_comb begin
    nxt_ctl = wr_ctl;
    if (park_lock) begin
      nxt_ctl.b1_src = ctl_q.b1_src;
      nxt_ctl.b1_div = ctl_q.b1_div;
      nxt_ctl.b1_n   = ctl_q.b1_n;
    end
  end

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RST;
      cmt0_q <= RST_DIV;
      cmt1_q <= RST_DIV;
      req0_q <= 1'b0;
      req1_q <= 1'b0;
    end else begin
      if (cfg_we) ctl_q <= nxt_ctl;
      if (commit_fall) begin
        cmt0_q <= nxt_ctl.b0_n;
        req0_q <= ~req0_q;
        if (!park_lock) begin
          cmt1_q <= nxt_ctl.b1_n;
          req1_q <= ~req1_q;
        end
      end
    end
  end

  clk_branch u_br0 (
    .rst_n    (rst_n),
    .ref_clk  (refs),
    .src      (ctl_q.b0_src),
    .use_div  (ctl_q.b0_div),
    .req_t    (req0_q),
    .cmt_n    (cmt0_q),
    .ack_t    (ack_raw[0]),
    .pre_act  (b0_pre),
    .post_act (b0_post),
    .clk_o    (br0_clk)
  );

  clk_branch u_br1 (
    .rst_n    (rst_n),
    .ref_clk  (refs),
    .src      (ctl_q.b1_src),
    .use_div  (ctl_q.b1_div),
    .req_t    (req1_q),
    .cmt_n    (cmt1_q),
    .ack_t    (ack_raw[1]),
    .pre_act  (b1_pre),
    .post_act (b1_post),
    .clk_o    (br1_clk)
  );

  glitchless_mux #(.N(2), .RST_IDX(0)) u_dyn (
    .rst_n   (rst_n),
    .clk_in  ({br1_clk, br0_clk}),
    .sel_oh  (pair_onehot(ctl_q.br_sel)),
    .clk_out (dyn_clk),
    .act_o   (dyn_act)
  );

  glitchless_mux #(.N(2), .RST_IDX(0)) u_fin (
    .rst_n   (rst_n),
    .clk_in  ({pll_clk, dyn_clk}),
    .sel_oh  (pair_onehot(ctl_q.use_pll)),
    .clk_out (cpu_clk),
    .act_o   (fin_act)
  );

  assign fb_raw  = {fin_act, dyn_act, b1_post, b1_pre, b0_post, b0_pre};
  assign fb_want = {pair_onehot(ctl_q.use_pll), pair_onehot(ctl_q.br_sel),
                    pair_onehot(ctl_q.b1_div), src_onehot(ctl_q.b1_src),
                    pair_onehot(ctl_q.b0_div), src_onehot(ctl_q.b0_src)};

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_s1  <= FB_RST;
      fb_s2  <= FB_RST;
      ack_s1 <= '0;
      ack_s2 <= '0;
    end else begin
      fb_s1  <= fb_raw;
      fb_s2  <= fb_s1;
      ack_s1 <= ack_raw;
      ack_s2 <= ack_s1;
    end
  end

  assign cfg_done = (fb_s2 == fb_want) && (ack_s2 == {req1_q, req0_q});

  AST_PARK_FROZEN: assert property (@(posedge cfg_clk) disable iff (!rst_n) (cfg_we && park_lock) |=> ($stable({ctl_q.b1_src, ctl_q.b1_div, ctl_q.b1_n}) && $stable(cmt1_q))) else $error("parking branch modified"); // R8
  AST_COMMIT_ON_FALL: assert property (@(posedge cfg_clk) disable iff (!rst_n) !commit_fall |=> ($stable(cmt0_q) && $stable(cmt1_q))) else $error("divider committed without falling commit bit"); // R5
  AST_DONE_DROP_COMMIT: assert property (@(posedge cfg_clk) disable iff (!rst_n) (commit_fall && cfg_done) |=> !cfg_done) else $error("done stayed high after commit"); // R9
  AST_DONE_DROP_SWITCH: assert property (@(posedge cfg_clk) disable iff (!rst_n) (cfg_we && cfg_done && (wr_ctl.br_sel != ctl_q.br_sel)) |=> !cfg_done) else $error("done stayed high after switch"); // R9
endmodule

// File: tb/cpu_clk_tree_tb_top.sv
`timescale 1ns/1ps
module cpu_clk_tree_tb_top;
  import cpu_clk_pkg::*;

  localparam real CLK_PERIOD = 10.0;
  localparam real P_OSC = 20.0;
  localparam real P_F2  = 8.0;
  localparam real P_F3  = 12.0;
  localparam real P_PLL = 6.0;

  logic             rst_n = 1'b0;
  logic             cfg_clk = 1'b0;
  logic             cfg_we = 1'b0;
  logic [CTL_W-1:0] cfg_wdata = '0;
  logic             osc_clk = 1'b0, fdiv2_clk = 1'b0, fdiv3_clk = 1'b0, pll_clk = 1'b0;
  logic             cpu_clk, cfg_done;

  int   checks = 0;
  int   fails  = 0;
  ctl_t m;
  int   c0, c1;
  real  min_w = 1.0e9;
  real  last_t = 0.0;
  bit   mon_on = 1'b0;

  cpu_clk_tree dut_i (
    .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .osc_clk(osc_clk), .fdiv2_clk(fdiv2_clk), .fdiv3_clk(fdiv3_clk), .pll_clk(pll_clk),
    .cpu_clk(cpu_clk), .cfg_done(cfg_done)
  );

  always #(CLK_PERIOD/2) cfg_clk = ~cfg_clk;
  initial begin #0.7; forever #(P_OSC/2) osc_clk = ~osc_clk; end
  initial begin #1.3; forever #(P_F2/2) fdiv2_clk = ~fdiv2_clk; end
  initial begin #2.1; forever #(P_F3/2) fdiv3_clk = ~fdiv3_clk; end
  initial begin #0.4; forever #(P_PLL/2) pll_clk = ~pll_clk; end

  // pulse width monitor for glitch detection
  always @(posedge cpu_clk or negedge cpu_clk) begin
    if (mon_on && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
    last_t = $realtime;
  end

  task automatic check(input bit ok, input string req, input real act, input real exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", req, act, exp);
    end
  endtask

  function automatic real ratio_of(input int n);
    return (n == 0) ? 2.0 : real'(n + 1);
  endfunction

  function automatic real exp_period();
    logic [1:0] code;
    logic       dv;
    int         c;
    real        s;
    if (m.use_pll) return P_PLL;
    if (m.br_sel) begin code = m.b1_src; dv = m.b1_div; c = c1; end
    else begin code = m.b0_src; dv = m.b0_div; c = c0; end
    s = (code == 2'd1) ? P_F2 : (code == 2'd2) ? P_F3 : P_OSC;
    if (dv) s = s * ratio_of(c);
    return s;
  endfunction

  // write with model update: branch 1 frozen while selected, commit on falling bit
  task automatic wr(input ctl_t v);
    ctl_t n;
    n = v;
    if (m.br_sel) begin n.b1_src = m.b1_src; n.b1_div = m.b1_div; n.b1_n = m.b1_n; end
    if (m.commit && !v.commit) begin
      c0 = int'(n.b0_n);
      if (!m.br_sel) c1 = int'(n.b1_n);
    end
    m = n;
    @(negedge cfg_clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge cfg_clk);
    cfg_we = 1'b0;
  endtask

  task automatic commit_seq(input ctl_t v);
    ctl_t t;
    t = m; t.commit = 1'b1; wr(t);
    v.commit = 1'b1; wr(v);
    v.commit = 1'b0; wr(v);
    check(cfg_done == 1'b0, "R9 done low after commit", real'(cfg_done), 0.0);
  endtask

  task automatic wait_done(input string req);
    int k;
    k = 0;
    while (!cfg_done && k < 6000) begin
      @(negedge cfg_clk);
      k++;
    end
    check(cfg_done == 1'b1, req, real'(cfg_done), 1.0);
  endtask

  task automatic check_period(input string req);
    real t0, p, e;
    wait_done({req, " settle"});
    repeat (3) @(posedge cpu_clk);
    t0 = $realtime;
    @(posedge cpu_clk);
    p = $realtime - t0;
    e = exp_period();
    check(((p - e) < 0.01) && ((e - p) < 0.01), req, p, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    ctl_t v;
    int   seed;
    seed = $urandom(32'h5EED_C10C);
    m = CTL_RST; c0 = 1; c1 = 1;
    repeat (5) @(negedge cfg_clk);
    rst_n = 1'b1;
    @(negedge cfg_clk);
    // R1 reset state
    check(cfg_done == 1'b1, "R1 done after reset", real'(cfg_done), 1.0);
    mon_on = 1'b1;
    check_period("R1 crystal undivided period");

    // R2 source codes on branch 0
    v = m; v.b0_src = 2'd1; wr(v);
    check(cfg_done == 1'b0, "R9 done low after source change", real'(cfg_done), 0.0);
    check_period("R2 fixed/2 source");
    v = m; v.b0_src = 2'd2; wr(v); check_period("R2 fixed/3 source");
    v = m; v.b0_src = 2'd3; wr(v); check_period("R2 code 3 is crystal");
    v = m; v.b0_src = 2'd0; wr(v);

    // R3 divide enable with reset ratio
    v = m; v.b0_div = 1'b1; wr(v); check_period("R3 divide by reset ratio");
    // R5 staged value without falling commit leaves output alone
    v = m; v.b0_n = 6'd5; wr(v); check_period("R5 staged value not applied");
    v = m; v.commit = 1'b1; wr(v);
    v = m; v.b0_n = 6'd9; wr(v); check_period("R5 commit high not applied");
    v = m; v.commit = 1'b0; wr(v);
    check(cfg_done == 1'b0, "R9 done low after commit", real'(cfg_done), 0.0);
    check_period("R6 ratio 10 applied after commit");
    v = m; v.b0_n = 6'd0; commit_seq(v); check_period("R3 N=0 gives ratio 2");
    v = m; v.b0_n = 6'd63; v.b0_src = 2'd1; commit_seq(v); check_period("R3 N=63 max ratio");

    // R4 branch 1 and PLL
    v = m; v.b1_src = 2'd2; v.b1_div = 1'b1; v.b1_n = 6'd2; commit_seq(v);
    wait_done("R9 branch 1 prepared");
    v = m; v.br_sel = 1'b1; wr(v);
    check(cfg_done == 1'b0, "R9 done low after branch switch", real'(cfg_done), 0.0);
    check_period("R4 branch 1 selected");
    v = m; v.use_pll = 1'b1; wr(v); check_period("R4 PLL selected");
    v = m; v.use_pll = 1'b0; wr(v); check_period("R4 back to dynamic path");

    // R8 parking branch frozen while active
    v = m; v.b1_src = 2'd0; v.b1_div = 1'b0; wr(v); check_period("R8 locked source write ignored");
    v = m; v.b1_n = 6'd7; commit_seq(v); check_period("R8 locked commit ignored");
    v = m; v.br_sel = 1'b0; wr(v); check_period("R8 back on branch 0");
    v = m; v.br_sel = 1'b1; wr(v); check_period("R8 branch 1 ratio kept");

    // constrained random: reprogram the idle branch, then hop onto it
    for (int it = 0; it < 16; it++) begin
      v = m;
      if (m.br_sel) begin
        v.b0_src = 2'($urandom_range(3)); v.b0_div = 1'($urandom_range(1)); v.b0_n = 6'($urandom_range(31));
      end else begin
        v.b1_src = 2'($urandom_range(3)); v.b1_div = 1'($urandom_range(1)); v.b1_n = 6'($urandom_range(31));
      end
      commit_seq(v);
      wait_done("R9 random commit settle");
      v = m; v.br_sel = ~m.br_sel; v.use_pll = ($urandom_range(3) == 0);
      wr(v);
      check(cfg_done == 1'b0, "R9 done low after random switch", real'(cfg_done), 0.0);
      check_period("R4 random period");
    end

    // R7 no runt pulses across every switch above
    check(min_w > (P_PLL / 2.0) - 0.01, "R7 minimum pulse width", min_w, P_PLL / 2.0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule